// File: doc/BRIEF.md
# Memory Return Fill and Writeback Sequencer

This block is the back end of one cache slice, between the slice's miss-handling logic and a DRAM controller. Outgoing, it keeps a queue of cache misses and a queue of dirty-line writebacks, and issues one of them to the DRAM request port each cycle the controller has room. Incoming, it files DRAM responses into a read-return queue and a write-return queue.

Each cycle it works on at most one return. The return comes from the active merge chain of the miss-status block, which holds requests that merged onto a line now filled. If no chain is active, the return is the oldest read response, and failing that the oldest write response. A read return becomes a reply to the requester and fills the line if the cache does not hold it yet. A fill that evicts a dirty line makes a full-line writeback. The block keeps retrying that writeback until the writeback queue has room, and it does not send the reply a second time. A write return is retired at once. The cache arrays and the DRAM timing are outside the block. The probe, the fill and the eviction are single-cycle handshakes on the ports.

Top module: `mem_return_seq`

## Requirements
- R1: After reset no DRAM request, reply, fill, miss-status notification or chain pop is driven, and `miss_full` is low.
- R2: A DRAM request is issued only while `dram_full` is low. A queued writeback always goes before a queued miss. Misses leave in the order they were pushed.
- R3: `dram_rsp_take` is high only while neither return queue is full. A response with `dram_rsp_write` or `dram_rsp_wb` set goes to the write-return queue, and any other response goes to the read-return queue.
- R4: When no return is in progress, a valid merge chain entry is taken first (`chain_pop`). Otherwise the oldest read return is taken, and only after that the oldest write return.
- R5: Taking a DRAM return pulses `ms_notify` with its address and writeback flag. If `chain_valid` is high in the next cycle, the chain head replaces the popped return and is processed in its place.
- R6: A read return raises `reply_valid`, carrying its address and id, only while `reply_full` is low. `fill_valid` rises with that reply only when `line_present` is low.
- R7: When a fill reports `evict_valid`, the evicted address is sent to DRAM as a request with write=1, writeback=1 and id 0. The writeback is retried every cycle while the writeback queue is full, and the reply is not sent again.
- R8: A write return is retired with no reply and no fill.
- R9: A held eviction address of all ones means that no writeback is pending. A writeback can be pending only while a return is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_push | input | 1 | Push a miss into the miss queue |
| miss_addr | input | AW | Miss line address |
| miss_write | input | 1 | Miss is a write (no allocate) |
| miss_id | input | IW | Requester id of the miss |
| miss_full | output | 1 | Miss queue full |
| dram_full | input | 1 | DRAM scheduler cannot accept a request |
| dram_req_valid | output | 1 | Request issued to DRAM this cycle |
| dram_req_addr | output | AW | Request address |
| dram_req_write | output | 1 | Request is a write |
| dram_req_wb | output | 1 | Request is a generated writeback |
| dram_req_id | output | IW | Request id (0 for writebacks) |
| dram_rsp_valid | input | 1 | DRAM response offered |
| dram_rsp_addr | input | AW | Response address |
| dram_rsp_write | input | 1 | Response belongs to a write |
| dram_rsp_wb | input | 1 | Response belongs to a writeback |
| dram_rsp_id | input | IW | Response id |
| dram_rsp_take | output | 1 | Response accepted this cycle |
| ms_notify | output | 1 | A new DRAM return was taken |
| ms_notify_addr | output | AW | Address of that return |
| ms_notify_wb | output | 1 | That return was a writeback |
| chain_valid | input | 1 | Merge chain has a head entry |
| chain_addr | input | AW | Chain head address |
| chain_id | input | IW | Chain head id |
| chain_write | input | 1 | Chain head is a write |
| chain_pop | output | 1 | Chain head consumed this cycle |
| reply_full | input | 1 | Reply queue cannot accept |
| reply_valid | output | 1 | Reply pushed this cycle |
| reply_addr | output | AW | Reply address |
| reply_id | output | IW | Reply id |
| line_present | input | 1 | Probe result for `reply_addr` |
| fill_valid | output | 1 | Fill the line at `fill_addr` |
| fill_addr | output | AW | Fill address |
| evict_valid | input | 1 | The fill evicts a dirty line |
| evict_addr | input | AW | Evicted line address |

## Verification
The case that needs the most care is a writeback retry and the dispatch of an older writeback landing in the same cycle. The bench fills the two-entry writeback queue while DRAM reports full, so a third eviction stays pending. It then lifts the full flag. In the cycle after the queue drains one entry, the pending writeback must enter the queue while the next queued writeback leaves for DRAM. The scoreboard judges this by the order of the DRAM requests (three writebacks, then the held miss) and by the absence of any repeated reply.

// File: rtl/mem_return_seq.sv
module mem_return_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

module mem_return_seq #(
  parameter int AW        = 32,
  parameter int IW        = 8,
  parameter int MQ_DEPTH  = 8,
  parameter int WBQ_DEPTH = 4,
  parameter int RQ_DEPTH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_push,
  input  logic [AW-1:0] miss_addr,
  input  logic          miss_write,
  input  logic [IW-1:0] miss_id,
  output logic          miss_full,
  input  logic          dram_full,
  output logic          dram_req_valid,
  output logic [AW-1:0] dram_req_addr,
  output logic          dram_req_write,
  output logic          dram_req_wb,
  output logic [IW-1:0] dram_req_id,
  input  logic          dram_rsp_valid,
  input  logic [AW-1:0] dram_rsp_addr,
  input  logic          dram_rsp_write,
  input  logic          dram_rsp_wb,
  input  logic [IW-1:0] dram_rsp_id,
  output logic          dram_rsp_take,
  output logic          ms_notify,
  output logic [AW-1:0] ms_notify_addr,
  output logic          ms_notify_wb,
  input  logic          chain_valid,
  input  logic [AW-1:0] chain_addr,
  input  logic [IW-1:0] chain_id,
  input  logic          chain_write,
  output logic          chain_pop,
  input  logic          reply_full,
  output logic          reply_valid,
  output logic [AW-1:0] reply_addr,
  output logic [IW-1:0] reply_id,
  input  logic          line_present,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  input  logic          evict_valid,
  input  logic [AW-1:0] evict_addr
);
  localparam logic [AW-1:0] NO_EVICT = '1;
  localparam int MW = AW + IW + 1;
  localparam int RW = AW + IW;

  logic          mq_empty, mq_full, wq_empty, wq_full;
  logic          rq_empty, rq_full, xq_empty, xq_full;
  logic [MW-1:0] mq_dout, xq_dout;
  logic [AW-1:0] wq_dout;
  logic [RW-1:0] rq_dout;

  logic          cur_valid, cur_chk, cur_write;
  logic [AW-1:0] cur_addr, evict_q;
  logic [IW-1:0] cur_id;

  // dispatch to DRAM
  wire issue_wb   = !dram_full && !wq_empty;
  wire issue_miss = !dram_full && wq_empty && !mq_empty;

  assign miss_full      = mq_full;
  assign dram_req_valid = issue_wb || issue_miss;
  assign dram_req_addr  = issue_wb ? wq_dout : mq_dout[AW-1:0];
  assign dram_req_write = issue_wb || mq_dout[MW-1];
  assign dram_req_wb    = issue_wb;
  assign dram_req_id    = issue_wb ? '0 : mq_dout[AW +: IW];

  // response intake
  wire rsp_to_wr = dram_rsp_write || dram_rsp_wb;
  assign dram_rsp_take = dram_rsp_valid && !rq_full && !xq_full;

  // return selection
  wire idle   = !cur_valid;
  wire pop_rd = idle && !chain_valid && !rq_empty;
  wire pop_wr = idle && !chain_valid && rq_empty && !xq_empty;
  assign chain_pop = chain_valid && (idle || cur_chk);

  assign ms_notify      = pop_rd || pop_wr;
  assign ms_notify_addr = pop_rd ? rq_dout[AW-1:0] : xq_dout[AW-1:0];
  assign ms_notify_wb   = pop_wr && xq_dout[MW-1];

  // processing
  wire busy    = cur_valid && !cur_chk;
  wire pend    = (evict_q != NO_EVICT);
  wire rd_act  = busy && !cur_write;

  assign reply_valid = rd_act && !pend && !reply_full;
  assign reply_addr  = cur_addr;
  assign reply_id    = cur_id;
  assign fill_valid  = reply_valid && !line_present;
  assign fill_addr   = cur_addr;

  wire           new_ev  = fill_valid && evict_valid;
  wire [AW-1:0]  ev_addr = pend ? evict_q : evict_addr;
  wire           wb_push = rd_act && (pend || new_ev) && !wq_full;
  wire           done    = busy && (cur_write || (reply_valid && !new_ev) || wb_push);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_chk   <= 1'b0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_id    <= '0;
      evict_q   <= NO_EVICT;
    end else begin
      if (chain_pop) begin
        cur_valid <= 1'b1;
        cur_chk   <= 1'b0;
        cur_addr  <= chain_addr;
        cur_id    <= chain_id;
        cur_write <= chain_write;
      end else if (pop_rd) begin
        cur_valid <= 1'b1;
        cur_chk   <= 1'b1;
        cur_addr  <= rq_dout[AW-1:0];
        cur_id    <= rq_dout[AW +: IW];
        cur_write <= 1'b0;
      end else if (pop_wr) begin
        cur_valid <= 1'b1;
        cur_chk   <= 1'b1;
        cur_addr  <= xq_dout[AW-1:0];
        cur_id    <= xq_dout[AW +: IW];
        cur_write <= 1'b1;
      end else if (cur_chk) begin
        cur_chk <= 1'b0;
      end else if (done) begin
        cur_valid <= 1'b0;
      end

      if (done)        evict_q <= NO_EVICT;
      else if (new_ev) evict_q <= evict_addr;
    end
  end

  mem_return_seq_fifo #(.W(MW), .DEPTH(MQ_DEPTH)) u_missq (
    .clk(clk), .rst_n(rst_n), .push(miss_push), .din({miss_write, miss_id, miss_addr}),
    .pop(issue_miss), .dout(mq_dout), .empty(mq_empty), .full(mq_full));

  mem_return_seq_fifo #(.W(AW), .DEPTH(WBQ_DEPTH)) u_wbq (
    .clk(clk), .rst_n(rst_n), .push(wb_push), .din(ev_addr),
    .pop(issue_wb), .dout(wq_dout), .empty(wq_empty), .full(wq_full));

  mem_return_seq_fifo #(.W(RW), .DEPTH(RQ_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(dram_rsp_take && !rsp_to_wr),
    .din({dram_rsp_id, dram_rsp_addr}),
    .pop(pop_rd), .dout(rq_dout), .empty(rq_empty), .full(rq_full));

  mem_return_seq_fifo #(.W(MW), .DEPTH(RQ_DEPTH)) u_wrq (
    .clk(clk), .rst_n(rst_n), .push(dram_rsp_take && rsp_to_wr),
    .din({dram_rsp_wb, dram_rsp_id, dram_rsp_addr}),
    .pop(pop_wr), .dout(xq_dout), .empty(xq_empty), .full(xq_full));
endmodule

// File: rtl/mem_return_seq_chk.sv
module mem_return_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dram_full,
  input logic          dram_req_valid,
  input logic          dram_rsp_valid,
  input logic          dram_rsp_take,
  input logic          ms_notify,
  input logic          chain_pop,
  input logic          reply_full,
  input logic          reply_valid,
  input logic          fill_valid,
  input logic          cur_valid,
  input logic          wq_full,
  input logic [AW-1:0] evict_q
);
  wire pend = (evict_q != '1);

  AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dram_full |-> !dram_req_valid); // R2
  AST_TAKE_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    dram_rsp_take |-> dram_rsp_valid); // R3
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(chain_pop && ms_notify)); // R4
  AST_NOTIFY_STARTS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ms_notify |=> cur_valid); // R5
  AST_REPLY_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    reply_full |-> !reply_valid); // R6
  AST_FILL_WITH_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> reply_valid); // R6
  AST_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !reply_valid); // R7
  AST_RETRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wq_full) |=> pend); // R7
  AST_PEND_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> cur_valid); // R9
endmodule

bind mem_return_seq mem_return_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_full(dram_full), .dram_req_valid(dram_req_valid),
  .dram_rsp_valid(dram_rsp_valid), .dram_rsp_take(dram_rsp_take), .ms_notify(ms_notify),
  .chain_pop(chain_pop), .reply_full(reply_full), .reply_valid(reply_valid),
  .fill_valid(fill_valid), .cur_valid(cur_valid), .wq_full(wq_full), .evict_q(evict_q));

// File: tb/test_mem_return_seq.sv
module test_mem_return_seq;
  localparam int AW = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic miss_push = 0, miss_write = 0, dram_full = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [IW-1:0] miss_id = '0;
  logic dram_rsp_valid = 0, dram_rsp_write = 0, dram_rsp_wb = 0;
  logic [AW-1:0] dram_rsp_addr = '0;
  logic [IW-1:0] dram_rsp_id = '0;
  logic chain_valid = 0, chain_write = 0;
  logic [AW-1:0] chain_addr = '0;
  logic [IW-1:0] chain_id = '0;
  logic reply_full = 0, line_present = 0, evict_valid = 0;
  logic [AW-1:0] evict_addr = '0;

  logic miss_full, dram_req_valid, dram_req_write, dram_req_wb, dram_rsp_take;
  logic [AW-1:0] dram_req_addr, ms_notify_addr, reply_addr, fill_addr;
  logic [IW-1:0] dram_req_id, reply_id;
  logic ms_notify, ms_notify_wb, chain_pop, reply_valid, fill_valid;

  mem_return_seq #(.AW(AW), .IW(IW), .MQ_DEPTH(4), .WBQ_DEPTH(2), .RQ_DEPTH(2)) i_mem_return_seq (
    .clk(clk), .rst_n(rst_n), .miss_push(miss_push), .miss_addr(miss_addr),
    .miss_write(miss_write), .miss_id(miss_id), .miss_full(miss_full),
    .dram_full(dram_full), .dram_req_valid(dram_req_valid), .dram_req_addr(dram_req_addr),
    .dram_req_write(dram_req_write), .dram_req_wb(dram_req_wb), .dram_req_id(dram_req_id),
    .dram_rsp_valid(dram_rsp_valid), .dram_rsp_addr(dram_rsp_addr),
    .dram_rsp_write(dram_rsp_write), .dram_rsp_wb(dram_rsp_wb), .dram_rsp_id(dram_rsp_id),
    .dram_rsp_take(dram_rsp_take), .ms_notify(ms_notify), .ms_notify_addr(ms_notify_addr),
    .ms_notify_wb(ms_notify_wb), .chain_valid(chain_valid), .chain_addr(chain_addr),
    .chain_id(chain_id), .chain_write(chain_write), .chain_pop(chain_pop),
    .reply_full(reply_full), .reply_valid(reply_valid), .reply_addr(reply_addr),
    .reply_id(reply_id), .line_present(line_present), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .evict_valid(evict_valid), .evict_addr(evict_addr));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [21:0] q_req[$];   // {write, wb, id, addr}
  logic [19:0] q_rep[$];   // {id, addr}
  logic [15:0] q_fill[$];
  logic [16:0] q_ntf[$];   // {wb, addr}

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && !finished) begin
    if (dram_req_valid) begin
      if (q_req.size() == 0) check("R2 unexpected dram request", {10'd0, dram_req_write, dram_req_wb, dram_req_id, dram_req_addr}, 32'hFFFFFFFF);
      else check("R2/R7 dram request", {10'd0, dram_req_write, dram_req_wb, dram_req_id, dram_req_addr}, {10'd0, q_req.pop_front()});
    end
    if (reply_valid) begin
      if (q_rep.size() == 0) check("R6 unexpected reply", {12'd0, reply_id, reply_addr}, 32'hFFFFFFFF);
      else check("R6 reply", {12'd0, reply_id, reply_addr}, {12'd0, q_rep.pop_front()});
    end
    if (fill_valid) begin
      if (q_fill.size() == 0) check("R6 unexpected fill", {16'd0, fill_addr}, 32'hFFFFFFFF);
      else check("R6 fill", {16'd0, fill_addr}, {16'd0, q_fill.pop_front()});
    end
    if (ms_notify) begin
      if (q_ntf.size() == 0) check("R5 unexpected notify", {15'd0, ms_notify_wb, ms_notify_addr}, 32'hFFFFFFFF);
      else check("R5 notify", {15'd0, ms_notify_wb, ms_notify_addr}, {15'd0, q_ntf.pop_front()});
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_miss(input logic [AW-1:0] a, input logic [IW-1:0] id, input logic w);
    miss_push = 1; miss_addr = a; miss_id = id; miss_write = w;
    @(posedge clk); #1 miss_push = 0;
  endtask

  task automatic send_rsp(input logic [AW-1:0] a, input logic [IW-1:0] id, input logic w, input logic wb);
    dram_rsp_valid = 1; dram_rsp_addr = a; dram_rsp_id = id; dram_rsp_write = w; dram_rsp_wb = wb;
    do @(negedge clk); while (!dram_rsp_take);
    @(posedge clk); #1 dram_rsp_valid = 0;
  endtask

  task automatic serve_chain;
    do @(negedge clk); while (!chain_pop);
    @(posedge clk); #1 chain_valid = 0;
  endtask

  initial begin
    wait_cyc(20000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1 idle", {26'd0, dram_req_valid, reply_valid, fill_valid, ms_notify, chain_pop, miss_full}, 32'd0);
    wait_cyc(1);

    // R2: held while DRAM full, FIFO order afterwards
    dram_full = 1;
    push_miss(16'h0040, 4'd1, 1'b0);
    push_miss(16'h0080, 4'd2, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check("R2 no issue while full", {31'd0, dram_req_valid}, 32'd0);
    end
    wait_cyc(1);
    q_req.push_back({1'b0, 1'b0, 4'd1, 16'h0040});
    q_req.push_back({1'b1, 1'b0, 4'd2, 16'h0080});
    dram_full = 0;
    wait_cyc(6);

    // R6: read return with fill, no eviction
    q_ntf.push_back({1'b0, 16'h0100});
    q_rep.push_back({4'd3, 16'h0100});
    q_fill.push_back(16'h0100);
    send_rsp(16'h0100, 4'd3, 1'b0, 1'b0);
    wait_cyc(6);

    // R6: line already present, no fill
    line_present = 1;
    q_ntf.push_back({1'b0, 16'h0140});
    q_rep.push_back({4'd4, 16'h0140});
    send_rsp(16'h0140, 4'd4, 1'b0, 1'b0);
    wait_cyc(6);

    // R6: reply waits while reply queue full
    reply_full = 1;
    q_ntf.push_back({1'b0, 16'h0180});
    send_rsp(16'h0180, 4'd5, 1'b0, 1'b0);
    wait_cyc(8);
    q_rep.push_back({4'd5, 16'h0180});
    reply_full = 0;
    wait_cyc(6);

    // R7/R9/R2: evictions fill the writeback queue, third one retries
    dram_full = 1; line_present = 0; evict_valid = 1;
    push_miss(16'h0C00, 4'd9, 1'b0);
    evict_addr = 16'h0A00;
    q_ntf.push_back({1'b0, 16'h0200}); q_rep.push_back({4'd6, 16'h0200}); q_fill.push_back(16'h0200);
    send_rsp(16'h0200, 4'd6, 1'b0, 1'b0);
    wait_cyc(6);
    evict_addr = 16'h0A40;
    q_ntf.push_back({1'b0, 16'h0240}); q_rep.push_back({4'd7, 16'h0240}); q_fill.push_back(16'h0240);
    send_rsp(16'h0240, 4'd7, 1'b0, 1'b0);
    wait_cyc(6);
    evict_addr = 16'h0A80;
    q_ntf.push_back({1'b0, 16'h0280}); q_rep.push_back({4'd8, 16'h0280}); q_fill.push_back(16'h0280);
    send_rsp(16'h0280, 4'd8, 1'b0, 1'b0);
    wait_cyc(6);
    evict_addr = 16'h0EEE;
    wait_cyc(6);
    q_req.push_back({1'b1, 1'b1, 4'd0, 16'h0A00});
    q_req.push_back({1'b1, 1'b1, 4'd0, 16'h0A40});
    q_req.push_back({1'b1, 1'b1, 4'd0, 16'h0A80});
    q_req.push_back({1'b0, 1'b0, 4'd9, 16'h0C00});
    dram_full = 0;
    wait_cyc(10);
    evict_valid = 0;

    // R4: chain entry goes before a waiting read return
    line_present = 1; reply_full = 1;
    q_ntf.push_back({1'b0, 16'h0300});
    send_rsp(16'h0300, 4'd9, 1'b0, 1'b0);
    send_rsp(16'h0340, 4'd10, 1'b0, 1'b0);
    wait_cyc(6);
    chain_valid = 1; chain_addr = 16'h0380; chain_id = 4'd11; chain_write = 0;
    q_rep.push_back({4'd9, 16'h0300});
    q_rep.push_back({4'd11, 16'h0380});
    q_rep.push_back({4'd10, 16'h0340});
    q_ntf.push_back({1'b0, 16'h0340});
    reply_full = 0;
    serve_chain();
    wait_cyc(8);

    // R5: chain head replaces the popped return
    q_ntf.push_back({1'b0, 16'h0400});
    q_rep.push_back({4'd13, 16'h0400});
    send_rsp(16'h0400, 4'd12, 1'b0, 1'b0);
    do @(negedge clk); while (!ms_notify);
    @(posedge clk); #1;
    chain_valid = 1; chain_addr = 16'h0400; chain_id = 4'd13; chain_write = 0;
    serve_chain();
    wait_cyc(6);

    // R8: write returns retire silently, writeback flag reported
    q_ntf.push_back({1'b0, 16'h0500});
    q_ntf.push_back({1'b1, 16'h0540});
    send_rsp(16'h0500, 4'd14, 1'b1, 1'b0);
    send_rsp(16'h0540, 4'd0, 1'b1, 1'b1);
    wait_cyc(8);

    // R3/R4: intake blocked while write queue full, then read before write
    reply_full = 1;
    q_ntf.push_back({1'b0, 16'h0600});
    send_rsp(16'h0600, 4'd15, 1'b0, 1'b0);
    send_rsp(16'h0680, 4'd1, 1'b1, 1'b0);
    send_rsp(16'h06C0, 4'd2, 1'b1, 1'b0);
    dram_rsp_valid = 1; dram_rsp_addr = 16'h0640; dram_rsp_id = 4'd6; dram_rsp_write = 0; dram_rsp_wb = 0;
    repeat (5) begin
      @(negedge clk);
      check("R3 no take while return queue full", {31'd0, dram_rsp_take}, 32'd0);
    end
    wait_cyc(1);
    q_rep.push_back({4'd15, 16'h0600});
    q_rep.push_back({4'd6, 16'h0640});
    q_ntf.push_back({1'b0, 16'h0680});
    q_ntf.push_back({1'b0, 16'h0640});
    q_ntf.push_back({1'b0, 16'h06C0});
    reply_full = 0;
    do @(negedge clk); while (!dram_rsp_take);
    @(posedge clk); #1 dram_rsp_valid = 0;
    wait_cyc(12);

    check("R2 all requests seen", q_req.size(), 0);
    check("R6 all replies seen", q_rep.size(), 0);
    check("R6 all fills seen", q_fill.size(), 0);
    check("R5 all notifies seen", q_ntf.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule